// File: doc/BRIEF.md
# MDIO Indirect Register Write Sequencer

This block is a management-bus master that writes 16-bit values into a PHY over a two-wire MDC/MDIO link. A host presents one request that carries a PHY address, a 16-bit register address and a 16-bit value. In extended mode, the block turns that request into four consecutive write frames. These frames pass through the PHY's indirect access pair: the control register at 0x0D and the address/data register at 0x0E. The target address and then the value reach the extended register space this way. In direct mode, the low five address bits name an ordinary register, and a single write frame is sent.

Each frame is a preamble of ones followed by a 32-bit write frame, shifted out MSB first. MDC comes from a programmable divider of the system clock, and MDIO changes only when MDC falls. The host sees `busy` while a sequence runs and a one-cycle `done` at its end. A request is taken only while `busy` is low, so the frames of one extended write are never split by another request.

Top module: `mdio_xwrite_seq`

## Requirements
- R1: During and directly after reset, `busy`, `done`, `mdc` and `mdio_oe` are 0 and `mdio_o` is 1.
- R2: Each frame is 32 ones, then, MSB first: start bits 01, opcode 01, the 5-bit PHY address, the 5-bit register number, turnaround 10 and the 16-bit value.
- R3: An extended request (`req_ext`=1) sends four frames back to back, in this order: 0x0D←0x001F, 0x0E←address, 0x0D←0x401F, 0x0E←value.
- R4: A direct request (`req_ext`=0) sends one frame to register `req_addr[4:0]`; bits 15:5 of the address have no effect.
- R5: Each bit lasts 2·(div+1) system clocks. MDC is low for the first div+1 clocks and high for the rest. MDIO changes only in the cycle where MDC falls, or at acceptance.
- R6: The divider value is sampled when a request is accepted. Changing `div_i` while `busy` is high has no effect.
- R7: A request is accepted only in a cycle where `busy` is low. `req_valid` raised while `busy` is high is ignored, and that request is not served later.
- R8: PHY address, register address, value and mode are captured at acceptance. Later changes on those inputs do not alter the frames in progress.
- R9: `busy` rises in the cycle after acceptance. `done` is high for exactly one cycle, starting with the MDC fall that ends the last bit, and `busy` is low in that same cycle. A request presented during the `done` cycle is accepted.
- R10: While idle, `mdc` is 0, `mdio_oe` is 0 and `mdio_o` is 1. While `busy` is high, `mdio_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_i | input | DIV_W | MDC half period in system clocks, minus one |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_ext | input | 1 | 1 = extended four-frame write, 0 = direct single frame |
| req_phy | input | 5 | Target PHY address |
| req_addr | input | 16 | Extended register address, or register number in bits 4:0 |
| req_data | input | 16 | Value to write |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |

## Verification
The assertions check the following on every cycle:
- MDC stays low and `done` never coincides with `busy` while idle.
- MDIO is stable unless MDC falls.
- The preamble drives ones.
- A direct request never advances past its first frame.
- Captured request fields stay unchanged through a sequence.
- `done` lasts one cycle.

Only the bench's scenarios can show:
- that the bit stream carries the right control words in the right order;
- that requests and divider changes arriving during `busy` are dropped;
- that the upper address bits are ignored in direct mode;
- that a request held through the `done` cycle is served at once.

The bench does this by comparing every output on every clock against a queue-based model.

// File: rtl/mdio_seq_pkg.sv
package mdio_seq_pkg;

  localparam int FRAME_W = 32;

  localparam logic [1:0]  START_CODE = 2'b01;
  localparam logic [1:0]  WRITE_OP   = 2'b01;
  localparam logic [1:0]  TURN_WR    = 2'b10;
  localparam logic [4:0]  IND_CTL    = 5'h0D;
  localparam logic [4:0]  IND_DAT    = 5'h0E;
  localparam logic [15:0] CTL_ADDR_M = 16'h001F;
  localparam logic [15:0] CTL_DATA_M = 16'h401F;

  typedef struct packed {
    logic [4:0]  regno;
    logic [15:0] val;
  } mgmt_wr_t;

  // one clause-22 write frame, without preamble
  function automatic logic [FRAME_W-1:0] wr_frame(input logic [4:0] phy,
                                                  input mgmt_wr_t w);
    return {START_CODE, WRITE_OP, phy, w.regno, TURN_WR, w.val};
  endfunction

  // register/value pair for step idx of a request
  function automatic mgmt_wr_t seq_step(input logic ext, input logic [1:0] idx,
                                        input logic [15:0] addr,
                                        input logic [15:0] data);
    mgmt_wr_t w;
    if (!ext) begin
      w = '{regno: addr[4:0], val: data};
    end else begin
      case (idx)
        2'd0:    w = '{regno: IND_CTL, val: CTL_ADDR_M};
        2'd1:    w = '{regno: IND_DAT, val: addr};
        2'd2:    w = '{regno: IND_CTL, val: CTL_DATA_M};
        default: w = '{regno: IND_DAT, val: data};
      endcase
    end
    return w;
  endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             fall_tick
);

  logic [DIV_W-1:0] cnt;
  logic             half_end;

  assign half_end  = (cnt == div);
  assign fall_tick = run && mdc && half_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (half_end) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R10: the clock is parked low when not running
  assert_mdc_parked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> !mdc);

endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter #(
  parameter int LEN = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [LEN-1:0]           load_val,
  input  logic                     shift,
  output logic                     bit_o,
  output logic                     last,
  output logic [$clog2(LEN)-1:0]   bit_idx
);

  localparam int IDX_W = $clog2(LEN);

  logic [LEN-1:0] sh;

  assign bit_o = sh[LEN-1];
  assign last  = (bit_idx == IDX_W'(LEN-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '1;
      bit_idx <= '0;
    end else if (load) begin
      sh      <= load_val;
      bit_idx <= '0;
    end else if (shift) begin
      sh      <= {sh[LEN-2:0], 1'b1};
      bit_idx <= bit_idx + 1'b1;
    end
  end

endmodule

// File: rtl/mdio_xwrite_seq.sv
module mdio_xwrite_seq #(
  parameter int DIV_W    = 8,
  parameter int PRE_BITS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic             req_valid,
  input  logic             req_ext,
  input  logic [4:0]       req_phy,
  input  logic [15:0]      req_addr,
  input  logic [15:0]      req_data,
  output logic             busy,
  output logic             done,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe
);
  import mdio_seq_pkg::*;

  localparam int LEN   = PRE_BITS + FRAME_W;
  localparam int IDX_W = $clog2(LEN);

  logic [DIV_W-1:0] div_q;
  logic             ext_q;
  logic [4:0]       phy_q;
  logic [15:0]      addr_q, data_q;
  logic [1:0]       step_q;

  // named internal events
  logic             accept, fall_tick, last_bit, frame_end, seq_last, load;
  logic             ser_bit;
  logic [IDX_W-1:0] bit_idx;
  mgmt_wr_t         next_word;
  logic [4:0]       next_phy;
  logic [LEN-1:0]   load_val;

  assign accept    = req_valid && !busy;
  assign frame_end = fall_tick && last_bit;
  assign seq_last  = !ext_q || (step_q == 2'd3);
  assign load      = accept || (frame_end && !seq_last);

  assign next_word = accept ? seq_step(req_ext, 2'd0, req_addr, req_data)
                            : seq_step(ext_q, 2'(step_q + 2'd1), addr_q, data_q);
  assign next_phy  = accept ? req_phy : phy_q;
  assign load_val  = {{PRE_BITS{1'b1}}, wr_frame(next_phy, next_word)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      div_q  <= '0;
      ext_q  <= 1'b0;
      phy_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      step_q <= '0;
    end else begin
      done <= frame_end && seq_last;
      if (accept) begin
        busy   <= 1'b1;
        div_q  <= div_i;
        ext_q  <= req_ext;
        phy_q  <= req_phy;
        addr_q <= req_addr;
        data_q <= req_data;
        step_q <= '0;
      end else if (frame_end) begin
        if (seq_last) busy <= 1'b0;
        else          step_q <= step_q + 2'd1;
      end
    end
  end

  mdio_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q),
    .mdc(mdc), .fall_tick(fall_tick)
  );

  mdio_shifter #(.LEN(LEN)) u_sh (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
    .shift(fall_tick), .bit_o(ser_bit), .last(last_bit), .bit_idx(bit_idx)
  );

  assign mdio_o  = busy ? ser_bit : 1'b1;
  assign mdio_oe = busy;

  // R2: preamble bits are ones
  assert_preamble_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bit_idx < IDX_W'(PRE_BITS)) |-> mdio_o);

  // R4: a direct request never leaves its first frame
  assert_direct_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ext_q) |-> step_q == 2'd0);

  // R5: data moves only with a falling MDC
  assert_mdio_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdio_o));

  // R6 / R8: captured request stays put for the whole sequence
  assert_capture_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(phy_q) && $stable(addr_q) &&
                               $stable(data_q) && $stable(ext_q) && $stable(div_q)));

  // R9: done is a single cycle, after busy, with busy low
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)) ##1 !done);

  // R9: more frames keep the sequence busy
  assert_frames_chain_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !seq_last) |=> busy);

endmodule

// File: tb/tb_mdio_xwrite_seq.sv
module tb_mdio_xwrite_seq;

  localparam logic [4:0] IDLE = 5'b00010; // {busy,done,oe,mdio,mdc}

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  div_i = 8'd1;
  logic        req_valid = 1'b0;
  logic        req_ext = 1'b0;
  logic [4:0]  req_phy = '0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic busy, done, mdc, mdio_o, mdio_oe;

  always #5 clk = ~clk;

  mdio_xwrite_seq dut (
    .clk(clk), .rst_n(rst_n), .div_i(div_i), .req_valid(req_valid),
    .req_ext(req_ext), .req_phy(req_phy), .req_addr(req_addr),
    .req_data(req_data), .busy(busy), .done(done), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  logic [4:0] expq[$];
  bit         bitq[$];
  int vectors = 0, miscompares = 0, cycles = 0;
  bit finished = 0;

  task automatic add_field(input logic [15:0] v, input int w);
    for (int i = w - 1; i >= 0; i--) bitq.push_back(v[i]);
  endtask

  // R2: 32 ones, 01, 01, phy, reg, 10, value
  task automatic add_frame(input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] v);
    for (int i = 0; i < 32; i++) bitq.push_back(1'b1);
    add_field(16'h1, 2); add_field(16'h1, 2);
    add_field({11'd0, phy}, 5); add_field({11'd0, rg}, 5);
    add_field(16'h2, 2); add_field(v, 16);
  endtask

  // R3 / R4 / R5: expand a request into per-cycle expected outputs
  task automatic plan(input logic ext, input logic [4:0] phy,
                      input logic [15:0] addr, input logic [15:0] data,
                      input int dv);
    if (ext) begin
      add_frame(phy, 5'h0D, 16'h001F);
      add_frame(phy, 5'h0E, addr);
      add_frame(phy, 5'h0D, 16'h401F);
      add_frame(phy, 5'h0E, data);
    end else begin
      add_frame(phy, addr[4:0], data);
    end
    while (bitq.size() != 0) begin
      bit b = bitq.pop_front();
      for (int k = 0; k < 2 * (dv + 1); k++)
        expq.push_back({1'b1, 1'b0, 1'b1, b, (k >= dv + 1)});
    end
    expq.push_back(5'b01010); // R9 done cycle
  endtask

  // reference model, advanced on each edge
  always @(posedge clk) begin
    if (!rst_n) expq.delete();
    else begin
      logic [4:0] cur;
      cur = (expq.size() != 0) ? expq[0] : IDLE;
      if (expq.size() != 0) void'(expq.pop_front());
      if (req_valid && !cur[4]) // R7: accept only when not busy
        plan(req_ext, req_phy, req_addr, req_data, int'(div_i));
    end
  end

  // comparison away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      logic [4:0] e, a;
      string tag;
      e = (!rst_n || expq.size() == 0) ? IDLE : expq[0];
      a = {busy, done, mdio_oe, mdio_o, mdc};
      vectors++;
      if (a !== e) begin
        miscompares++;
        if (!rst_n) tag = "R1";
        else if (a[0] !== e[0]) tag = "R5";
        else if (a[1] !== e[1]) tag = "R2/R3/R4";
        else if (a[2] !== e[2]) tag = "R10";
        else if (a[3] !== e[3]) tag = "R9";
        else tag = "R7";
        $display("FAIL %s t=%0t {busy,done,oe,mdio,mdc} actual=%b expected=%b",
                 tag, $time, a, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog R9 actual=busy expected=idle");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic send(input logic ext, input logic [4:0] phy,
                      input logic [15:0] addr, input logic [15:0] data,
                      input logic [7:0] dv);
    req_ext = ext; req_phy = phy; req_addr = addr; req_data = data;
    div_i = dv; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (expq.size() != 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    // R1 / R10: reset and idle levels
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3: extended write, PHY 0
    send(1'b1, 5'd0, 16'h0134, 16'h00A1, 8'd1);
    wait_idle();

    // R4: direct write, upper address bits ignored, PHY 1
    send(1'b0, 5'd1, 16'hFFF2, 16'h0008, 8'd0);
    wait_idle();

    // R6 / R7 / R8: disturb inputs while busy
    send(1'b1, 5'd1, 16'h0139, 16'hBEEF, 8'd2);
    repeat (150) @(negedge clk);
    req_valid = 1'b1; req_ext = 1'b0; req_phy = 5'd7;
    req_addr = 16'h0003; req_data = 16'h1234; div_i = 8'd0;
    repeat (6) @(negedge clk);
    req_valid = 1'b0;
    wait_idle();

    // R9: request held through the done cycle is taken at once
    req_ext = 1'b0; req_phy = 5'd0; req_addr = 16'h0000;
    req_data = 16'h1140; div_i = 8'd3; req_valid = 1'b1;
    @(negedge clk);
    while (!done) @(negedge clk);
    req_phy = 5'd1; req_addr = 16'h0012; req_data = 16'hA5C3; div_i = 8'd1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle();

    // R5: slow divider, extended path
    send(1'b1, 5'd2, 16'hFFFF, 16'h0000, 8'd4);
    wait_idle();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule